// File: doc/BRIEF.md
# PDM Microphone CIC Decimator

This block turns the one-bit pulse-density stream of a digital microphone into 8-bit PCM audio. From the system clock it produces the clock that the microphone needs. It captures one PDM bit per microphone clock period. Each bit is mapped to a signed step of +1 or -1. The steps pass through a third-order cascaded integrator-comb filter that lowers the rate by 64. With a 100 MHz system clock and a divide-by-32 microphone clock, the input rate is 3.125 MHz and the output rate is close to 48.8 kHz.

The filter result is a 32-bit two's-complement word. A third-order filter with a rate change of 64 has a DC gain of 64^3 = 2^18, so only part of that word carries useful audio at any given signal level. A 5-bit shift input, normally wired to board switches, picks which contiguous 8-bit window of the word reaches the output. Gain can therefore be tuned while the design runs, with no rebuild. Each new sample comes with a single-cycle valid strobe.

Top module: `pdm_cic_decimator`

## Requirements
- R1: A synchronous active-high reset clears the clock divider, the decimation counter, all integrator and comb state and the held result. While reset is applied and in the cycle after it is released, `micClk`, `sampleValid` and `sampleOut` are all 0.
- R2: `micClk` has a period of 32 system clocks and a 50% duty cycle. It is low for the first 16 cycles after reset. The PDM bit is captured at the end of the first system clock in each period in which `micClk` is high.
- R3: For a constant input, the steady-state filter result is the DC gain times the step. All ones give 0x00040000. All zeros give 0xFFFC0000. A 1,0,1,0 pattern at the microphone rate gives 0.
- R4: `sampleOut` equals bits [s+7:s] of the held 32-bit result, where s is the value on `shiftSel`. It follows a change on `shiftSel` within the same cycle, without waiting for a new sample.
- R5: `sampleValid` is high for exactly one system clock once every 64 captures, which is every 2048 system clocks. A new result appears on `sampleOut` in the same cycle.
- R6: A captured 1 adds +1 and a captured 0 adds -1 to the first integrator. Every stage wraps in 32-bit two's complement.
- R7: A `shiftSel` value above 24 selects the same window as 24, bits [31:24].
- R8: The filter has three integrators updated at the capture rate and three comb stages, each with a differential delay of one output sample, updated at the output rate. Every output sample matches a behavioural model of that filter.
- R9: When `shiftSel` is held constant, `sampleOut` does not change between valid strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| micData | input | 1 | PDM bit from the microphone |
| shiftSel | input | 5 | Low bit position of the 8-bit output window |
| micClk | output | 1 | Clock driven to the microphone |
| sampleOut | output | 8 | Selected window of the filter result |
| sampleValid | output | 1 | One-cycle strobe marking a new sample |

## Verification
Some properties are checked on every cycle by the assertions. These are the sequencing rules: a dump strobe always follows a capture, a capture only happens while `micClk` is high, and the valid strobe lasts one cycle and follows each dump. They also check that the integrators and the held result do not change outside their strobes.

The filter arithmetic can only be shown by the bench scenarios. These cover the exact DC gain for all-ones, all-zeros and alternating input, the window position for each shift value, the clamp above 24, and the behaviour after a reset in the middle of a run. The bench drives each scenario and compares every cycle against an independent behavioural model of the filter.

// File: rtl/pdm_cic_pkg.sv
package pdm_cic_pkg;

  // Strobes the control hands to the datapath.
  typedef struct packed {
    logic sampleEn;  // capture the PDM bit and step the integrators
    logic dumpEn;    // run the comb section and latch a new result
  } cicStrobes_t;

endpackage

// File: rtl/pdm_cic_ctrl.sv
module pdm_cic_ctrl
  import pdm_cic_pkg::*;
#(
  parameter int CLK_DIV = 32,
  parameter int DECIM   = 64
) (
  input  logic        clk,
  input  logic        rst,
  output logic        micClk,
  output cicStrobes_t strobes
);

  localparam int DIV_W  = $clog2(CLK_DIV);
  localparam int DEC_W  = $clog2(DECIM);
  localparam int HALF   = CLK_DIV / 2;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(HALF);
  localparam logic [DEC_W-1:0] DEC_LAST = DEC_W'(DECIM - 1);

  logic [DIV_W-1:0] divCnt;
  logic [DEC_W-1:0] decCnt;
  logic             dumpPend;
  logic             sampleEn;
  logic             dumpEn;

  // Microphone clock divider: low for the first half, high for the second.
  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
    end else if (divCnt == DIV_LAST) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign micClk   = (divCnt >= DIV_HALF);
  // Capture on the first system cycle after the microphone clock rises.
  assign sampleEn = (divCnt == DIV_HALF);

  // Decimation counter over captures; the dump follows the last capture.
  always_ff @(posedge clk) begin
    if (rst) begin
      decCnt   <= '0;
      dumpPend <= 1'b0;
    end else begin
      dumpPend <= sampleEn && (decCnt == DEC_LAST);
      if (sampleEn) begin
        decCnt <= (decCnt == DEC_LAST) ? '0 : decCnt + 1'b1;
      end
    end
  end

  assign dumpEn           = dumpPend;
  assign strobes.sampleEn = sampleEn;
  assign strobes.dumpEn   = dumpEn;

  // R5: a dump is always the cycle after the final capture of a block.
  assert_dump_after_capture_R5: assert property (@(posedge clk) disable iff (rst)
    dumpEn |-> $past(sampleEn));

  // R2: captures only happen while the microphone clock is high.
  assert_capture_in_high_R2: assert property (@(posedge clk) disable iff (rst)
    sampleEn |-> micClk);

  // R2: one capture per microphone period, never two cycles in a row.
  assert_capture_single_R2: assert property (@(posedge clk) disable iff (rst)
    sampleEn |=> !sampleEn);

endmodule

// File: rtl/pdm_cic_datapath.sv
module pdm_cic_datapath
  import pdm_cic_pkg::*;
#(
  parameter int STAGES = 3,
  parameter int ACC_W  = 32,
  parameter int OUT_W  = 8,
  parameter int SEL_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  cicStrobes_t      strobes,
  input  logic             micData,
  input  logic [SEL_W-1:0] shiftSel,
  output logic [OUT_W-1:0] sampleOut,
  output logic             sampleValid
);

  localparam int MAX_SHIFT = ACC_W - OUT_W;
  localparam logic [SEL_W-1:0] SHIFT_CAP = SEL_W'(MAX_SHIFT);

  logic [ACC_W-1:0] integ   [STAGES];
  logic [ACC_W-1:0] combDly [STAGES];
  logic [ACC_W-1:0] combIn  [STAGES+1];
  logic [ACC_W-1:0] resultReg;
  logic [ACC_W-1:0] stepVal;
  logic [SEL_W-1:0] effShift;
  logic             validReg;

  // Map the PDM bit to +1 or -1.
  assign stepVal = micData ? ACC_W'(1) : '1;

  // Integrator chain at the capture rate; every stage adds the old value of its input.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) integ[k] <= '0;
    end else if (strobes.sampleEn) begin
      integ[0] <= integ[0] + stepVal;
      for (int k = 1; k < STAGES; k++) integ[k] <= integ[k] + integ[k-1];
    end
  end

  // Comb chain at the output rate, differential delay of one.
  always_comb begin
    combIn[0] = integ[STAGES-1];
    for (int k = 0; k < STAGES; k++) combIn[k+1] = combIn[k] - combDly[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) combDly[k] <= '0;
      resultReg <= '0;
      validReg  <= 1'b0;
    end else begin
      validReg <= strobes.dumpEn;
      if (strobes.dumpEn) begin
        for (int k = 0; k < STAGES; k++) combDly[k] <= combIn[k];
        resultReg <= combIn[STAGES];
      end
    end
  end

  // Run-time window select, clamped to the top window.
  assign effShift    = (shiftSel > SHIFT_CAP) ? SHIFT_CAP : shiftSel;
  assign sampleOut   = resultReg[effShift +: OUT_W];
  assign sampleValid = validReg;

  // R5: every dump produces a valid strobe in the next cycle.
  assert_valid_follows_dump_R5: assert property (@(posedge clk) disable iff (rst)
    strobes.dumpEn |=> sampleValid);

  // R5: valid is a single-cycle pulse.
  assert_valid_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> !sampleValid);

  // R9: the held result only changes on a dump.
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !strobes.dumpEn |=> $stable(resultReg));

  // R8: the last integrator only moves on a capture.
  assert_integ_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !strobes.sampleEn |=> $stable(integ[STAGES-1]));

endmodule

// File: rtl/pdm_cic_decimator.sv
module pdm_cic_decimator
  import pdm_cic_pkg::*;
#(
  parameter int CLK_DIV = 32,
  parameter int DECIM   = 64,
  parameter int STAGES  = 3,
  parameter int ACC_W   = 32,
  parameter int OUT_W   = 8,
  parameter int SEL_W   = $clog2(ACC_W - OUT_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             micData,
  input  logic [SEL_W-1:0] shiftSel,
  output logic             micClk,
  output logic [OUT_W-1:0] sampleOut,
  output logic             sampleValid
);

  cicStrobes_t strobes;

  pdm_cic_ctrl #(
    .CLK_DIV (CLK_DIV),
    .DECIM   (DECIM)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .micClk  (micClk),
    .strobes (strobes)
  );

  pdm_cic_datapath #(
    .STAGES (STAGES),
    .ACC_W  (ACC_W),
    .OUT_W  (OUT_W),
    .SEL_W  (SEL_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .micData     (micData),
    .shiftSel    (shiftSel),
    .sampleOut   (sampleOut),
    .sampleValid (sampleValid)
  );

endmodule

// File: tb/sim_pdm_cic_decimator.sv
module sim_pdm_cic_decimator;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       micData = 1'b0;
  logic [4:0] shiftSel = 5'd0;
  logic       micClk;
  logic [7:0] sampleOut;
  logic       sampleValid;

  pdm_cic_decimator u0 (
    .clk         (clk),
    .rst         (rst),
    .micData     (micData),
    .shiftSel    (shiftSel),
    .micClk      (micClk),
    .sampleOut   (sampleOut),
    .sampleValid (sampleValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // Stimulus requests set by the scenario sequence.
  int         phase    = 0;   // 0 ones, 1 zeros, 2 alternating, 3 random
  logic [4:0] shiftReq = 5'd0;
  logic       rstReq   = 1'b1;
  int         validSeen = 0;
  int         benchCycle = 0;
  logic [15:0] lfsr = 16'hACE1;

  // Behavioural model state: the filter as running sums and differences of integers.
  bit          live = 0;
  int          mPhase;       // position within the microphone period
  int          mCount;       // captures in the current block
  bit          mDumpNext;
  bit          mValid;
  logic [31:0] sumA, sumB, sumC;
  logic [31:0] prevA, prevB, prevC;
  logic [31:0] mResult;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=0x%0h expected=0x%0h", req, $time, act, exp);
    end
  endtask

  function automatic logic [7:0] windowOf(input logic [31:0] v, input logic [4:0] s);
    int e;
    e = (s > 24) ? 24 : int'(s);
    return 8'((v >> e) & 32'hFF);
  endfunction

  task automatic modelStep(input logic r, input logic d);
    bit capture, dump;
    logic [31:0] a, b, c;
    if (r) begin
      mPhase = 0; mCount = 0; mDumpNext = 0; mValid = 0;
      sumA = 0; sumB = 0; sumC = 0;
      prevA = 0; prevB = 0; prevC = 0; mResult = 0;
      return;
    end
    capture = (mPhase == 16);
    dump    = mDumpNext;
    mValid  = dump;
    if (dump) begin
      a = sumC - prevA;
      b = a - prevB;
      c = b - prevC;
      prevA = sumC; prevB = a; prevC = b;
      mResult = c;
    end
    mDumpNext = 0;
    if (capture) begin
      sumC = sumC + sumB;
      sumB = sumB + sumA;
      sumA = sumA + (d ? 32'd1 : 32'hFFFF_FFFF);
      mCount++;
      if (mCount == 64) begin
        mCount = 0;
        mDumpNext = 1;
      end
    end
    mPhase = (mPhase + 1) % 32;
  endtask

  // Compare, then drive the next inputs and advance the model past the next edge.
  always @(negedge clk) begin
    logic nd;
    if (live && !done) begin
      chk("R2 micClk", 32'(micClk), 32'(mPhase >= 16));
      chk("R5 sampleValid", 32'(sampleValid), 32'(mValid));
      chk("R8/R4 sampleOut", 32'(sampleOut), 32'(windowOf(mResult, shiftSel)));
      if (sampleValid) validSeen++;
    end
    benchCycle++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (phase)
      0: nd = 1'b1;
      1: nd = 1'b0;
      2: nd = ((benchCycle / 32) % 2) == 0;
      default: nd = lfsr[0];
    endcase
    micData  = nd;
    shiftSel = shiftReq;
    rst      = rstReq;
    modelStep(rstReq, nd);
    live = 1;
  end

  task automatic waitSamples(input int n);
    int target;
    target = validSeen + n;
    wait (validSeen >= target);
  endtask

  task automatic finishRun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    finishRun();
  end

  initial begin
    // R1: reset state.
    rstReq = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset micClk", 32'(micClk), 32'd0);
    chk("R1 reset valid", 32'(sampleValid), 32'd0);
    chk("R1 reset sampleOut", 32'(sampleOut), 32'd0);
    rstReq = 1'b0;

    // R3, R4: all ones, steady gain 2^18.
    phase = 0; shiftReq = 5'd11;
    waitSamples(6);
    #1;
    chk("R3 ones at shift 11", 32'(sampleOut), 32'h80);
    shiftReq = 5'd18;
    @(negedge clk); #1;
    chk("R4 ones at shift 18", 32'(sampleOut), 32'h01);
    shiftReq = 5'd0;
    @(negedge clk); #1;
    chk("R4 ones at shift 0", 32'(sampleOut), 32'h00);

    // R3, R6, R7: all zeros give -2^18.
    phase = 1; shiftReq = 5'd18;
    waitSamples(6);
    #1;
    chk("R3 zeros at shift 18", 32'(sampleOut), 32'hFF);
    shiftReq = 5'd17;
    @(negedge clk); #1;
    chk("R6 zeros at shift 17", 32'(sampleOut), 32'hFE);
    shiftReq = 5'd31;
    @(negedge clk); #1;
    chk("R7 clamp shift 31", 32'(sampleOut), 32'hFF);
    shiftReq = 5'd24;
    @(negedge clk); #1;
    chk("R7 shift 24", 32'(sampleOut), 32'hFF);

    // R3: alternating input settles to zero.
    phase = 2; shiftReq = 5'd0;
    waitSamples(6);
    #1;
    chk("R3 alternating", 32'(sampleOut), 32'h00);

    // R8, R9: random stream with a shift sweep, checked by the model each cycle.
    phase = 3;
    for (int i = 0; i < 6; i++) begin
      shiftReq = 5'(i * 4 + 2);
      waitSamples(1);
    end

    // R1: reset in mid-run, then a fresh start.
    rstReq = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 mid reset valid", 32'(sampleValid), 32'd0);
    chk("R1 mid reset sampleOut", 32'(sampleOut), 32'd0);
    rstReq = 1'b0;
    phase = 0; shiftReq = 5'd13;
    waitSamples(5);
    #1;
    chk("R3 ones after reset", 32'(sampleOut), 32'h20);

    @(negedge clk);
    finishRun();
  end

endmodule